// File: doc/BRIEF.md
# Clock Gate Controller with Software Enables, Hints and Busy Override

This block produces eight gated clocks from eight root clocks. Four are peripheral clocks: an IO clock divided by four, an IO clock divided by two, the full IO clock and a USB clock. Each peripheral clock is switched by its own bit in a software enable register. The other four serve transactional units: a cipher engine, a hash engine, a sponge hash engine and a big-number engine. Each unit clock is switched by its own bit in a software hint register. A busy unit keeps its clock running whatever the hint says.

Software writes and reads the registers through a plain write strobe and a combinational read port in the configuration clock domain. A global clock enable from the power manager qualifies every register bit. The qualified value passes through one flop clocked by the ungated root clock of the gate it controls. A latch-based gate then holds that value through each high phase of the root clock. A scan-mode input forces every gate open asynchronously, with no staging.

Top module: `cg_ctrl`

## Requirements
- R1: After reset the enable register (address 0) and the hint register (address 1) read back 4'hF, and every gated clock runs.
- R2: A write strobe with address 0 or 1 stores the data bits in that register on the next configuration clock edge, and a read of that address returns them.
- R3: Peripheral gate i passes the root high phase when bit i of the enable register AND the power-manager enable was true at the previous root rising edge. A register change first shows in the second root high phase after the write edge.
- R4: Unit gate i opens when the staged value of hint bit i AND the power-manager enable is true, or when idle input bit i is low (busy). A busy unit therefore keeps its clock even with its hint cleared.
- R5: With the power-manager enable low, every gate closes, except unit gates whose unit is busy.
- R6: When scan mode is high, every gated clock follows its root clock at once, within the same root high phase and regardless of registers, power enable or idle.
- R7: Address 2 reads the idle inputs after two configuration clock edges of synchronisation. Writes to address 2 change neither register.
- R8: Each enable bit and each hint bit controls only its own gated clock. Bit 0 maps to the divide-by-4 IO clock or the cipher unit, and bit 3 maps to the USB clock or the big-number unit.
- R9: Every gated clock is low whenever its root clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cfg_i | input | 1 | Configuration register clock |
| rst_ni | input | 1 | Asynchronous active-low reset for all domains |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 enables, 1 hints, 2 idle status (read-only) |
| wr_data_i | input | 4 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 4 | Read data, combinational from rd_addr_i |
| pwr_clk_en_i | input | 1 | Global clock enable from the power manager |
| scan_en_i | input | 1 | Asynchronous scan-mode override, opens all gates |
| idle_i | input | 4 | Per-unit idle flags, high when the unit is idle |
| peri_root_i | input | 4 | Peripheral root clocks |
| unit_root_i | input | 4 | Transactional unit root clocks |
| peri_gclk_o | output | 4 | Gated peripheral clocks |
| unit_gclk_o | output | 4 | Gated unit clocks |

## Verification
On every cycle the assertions check several properties. Each gated high phase must equal the enable staged at the previous root edge, or the forced-open state under scan. A busy unit must always have its clock running. Register writes must land one configuration edge later, and a write to the idle status address must leave both registers unchanged. Only the bench scenarios show the reset values, the two-edge latency of a peripheral switch-off, scan opening a closed gate partway through a high phase, the idle status synchronisation delay and the low level of every gate during the root low phase.

// File: rtl/cg_pkg.sv
`timescale 1ns/1ps
package cg_pkg;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLES = 2'd0,
        REG_HINTS   = 2'd1,
        REG_IDLE    = 2'd2,
        REG_SPARE   = 2'd3
    } cg_reg_e;

    // Peripheral clock bit positions (order is decoded by the gate array)
    localparam int unsigned PERI_IO_DIV4 = 0;
    localparam int unsigned PERI_IO_DIV2 = 1;
    localparam int unsigned PERI_IO      = 2;
    localparam int unsigned PERI_USB     = 3;

    // Transactional unit bit positions
    localparam int unsigned UNIT_CIPHER  = 0;
    localparam int unsigned UNIT_HASH    = 1;
    localparam int unsigned UNIT_SPONGE  = 2;
    localparam int unsigned UNIT_BIGNUM  = 3;
endpackage

// File: rtl/cg_cfg_regs.sv
`timescale 1ns/1ps
module cg_cfg_regs
    import cg_pkg::*;
#(
    parameter int unsigned NUM_PERI = 4,
    parameter int unsigned NUM_UNIT = 4,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned REG_W = (NUM_PERI > NUM_UNIT) ? NUM_PERI : NUM_UNIT
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [REG_W-1:0]    wr_data_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [REG_W-1:0]    rd_data_o,
    input  logic [NUM_UNIT-1:0] idle_i,
    output logic [NUM_PERI-1:0] enables_o,
    output logic [NUM_UNIT-1:0] hints_o
);
    logic [NUM_PERI-1:0] en_q;
    logic [NUM_UNIT-1:0] hint_q;
    logic [NUM_UNIT-1:0] idle_sync [SYNC_STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q   <= '1;
            hint_q <= '1;
        end else if (wr_en_i) begin
            if (wr_addr_i == REG_ENABLES) en_q   <= wr_data_i[NUM_PERI-1:0];
            if (wr_addr_i == REG_HINTS)   hint_q <= wr_data_i[NUM_UNIT-1:0];
        end
    end

    // Idle flags cross into the register domain through a flop chain
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)    idle_sync[s] <= '1;
                else if (s == 0) idle_sync[s] <= idle_i;
                else            idle_sync[s] <= idle_sync[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    always_comb begin
        rd_data_o = '0;
        unique case (cg_reg_e'(rd_addr_i))
            REG_ENABLES: rd_data_o[NUM_PERI-1:0] = en_q;
            REG_HINTS:   rd_data_o[NUM_UNIT-1:0] = hint_q;
            REG_IDLE:    rd_data_o[NUM_UNIT-1:0] = idle_sync[SYNC_STAGES-1];
            REG_SPARE:   rd_data_o = '0;
        endcase
    end

    assign enables_o = en_q;
    assign hints_o   = hint_q;

    AST_ENABLE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == REG_ENABLES) |=> (en_q == $past(wr_data_i[NUM_PERI-1:0]))); // R2
    AST_HINT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == REG_HINTS) |=> (hint_q == $past(wr_data_i[NUM_UNIT-1:0]))); // R2
    AST_IDLE_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == REG_IDLE) |=> ($stable(en_q) && $stable(hint_q))); // R7
endmodule

// File: rtl/cg_stage.sv
`timescale 1ns/1ps
module cg_stage #(
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o <= RST_VAL;
        else         q_o <= d_i;
    end
endmodule

// File: rtl/cg_icg.sv
`timescale 1ns/1ps
module cg_icg (
    input  logic clk_i,
    input  logic en_i,
    input  logic scan_i,
    output logic gclk_o
);
    logic lat_q;

    // Transparent while the root is low, so the enable is frozen for the high phase
    always_latch begin
        if (!clk_i) lat_q <= en_i;
    end

    // Scan bypasses the latch and opens the gate without staging
    assign gclk_o = clk_i & (lat_q | scan_i);
endmodule

// File: rtl/cg_ctrl.sv
`timescale 1ns/1ps
module cg_ctrl
    import cg_pkg::*;
#(
    parameter int unsigned NUM_PERI = 4,
    parameter int unsigned NUM_UNIT = 4,
    localparam int unsigned REG_W = (NUM_PERI > NUM_UNIT) ? NUM_PERI : NUM_UNIT
) (
    input  logic                clk_cfg_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [REG_W-1:0]    wr_data_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [REG_W-1:0]    rd_data_o,
    input  logic                pwr_clk_en_i,
    input  logic                scan_en_i,
    input  logic [NUM_UNIT-1:0] idle_i,
    input  logic [NUM_PERI-1:0] peri_root_i,
    input  logic [NUM_UNIT-1:0] unit_root_i,
    output logic [NUM_PERI-1:0] peri_gclk_o,
    output logic [NUM_UNIT-1:0] unit_gclk_o
);
    logic [NUM_PERI-1:0] enables;
    logic [NUM_UNIT-1:0] hints;
    logic [NUM_PERI-1:0] peri_stage;
    logic [NUM_UNIT-1:0] unit_stage;

    cg_cfg_regs #(
        .NUM_PERI(NUM_PERI),
        .NUM_UNIT(NUM_UNIT)
    ) u_regs (
        .clk_i     (clk_cfg_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .idle_i    (idle_i),
        .enables_o (enables),
        .hints_o   (hints)
    );

    generate
        for (genvar i = 0; i < NUM_PERI; i++) begin : g_peri
            cg_stage #(.RST_VAL(1'b1)) u_stage (
                .clk_i  (peri_root_i[i]),
                .rst_ni (rst_ni),
                .d_i    (enables[i] & pwr_clk_en_i),
                .q_o    (peri_stage[i])
            );
            cg_icg u_gate (
                .clk_i  (peri_root_i[i]),
                .en_i   (peri_stage[i]),
                .scan_i (scan_en_i),
                .gclk_o (peri_gclk_o[i])
            );

            AST_PERI_GATE_STAGED: assert property (@(negedge peri_root_i[i]) disable iff (!rst_ni)
                !scan_en_i |-> (peri_gclk_o[i] == $past(peri_stage[i]))); // R3
            AST_PERI_SCAN_OPEN: assert property (@(negedge peri_root_i[i]) disable iff (!rst_ni)
                scan_en_i |-> peri_gclk_o[i]); // R6
        end

        for (genvar j = 0; j < NUM_UNIT; j++) begin : g_unit
            cg_stage #(.RST_VAL(1'b1)) u_stage (
                .clk_i  (unit_root_i[j]),
                .rst_ni (rst_ni),
                .d_i    (hints[j] & pwr_clk_en_i),
                .q_o    (unit_stage[j])
            );
            // Idle already lives in this root domain: no staging
            cg_icg u_gate (
                .clk_i  (unit_root_i[j]),
                .en_i   (unit_stage[j] | ~idle_i[j]),
                .scan_i (scan_en_i),
                .gclk_o (unit_gclk_o[j])
            );

            AST_UNIT_BUSY_RUNS: assert property (@(negedge unit_root_i[j]) disable iff (!rst_ni)
                $past(!idle_i[j]) |-> unit_gclk_o[j]); // R4
            AST_UNIT_GATE_STAGED: assert property (@(negedge unit_root_i[j]) disable iff (!rst_ni)
                (!scan_en_i && $past(idle_i[j])) |-> (unit_gclk_o[j] == $past(unit_stage[j]))); // R4
            AST_UNIT_SCAN_OPEN: assert property (@(negedge unit_root_i[j]) disable iff (!rst_ni)
                scan_en_i |-> unit_gclk_o[j]); // R6
        end
    endgenerate
endmodule

// File: tb/cg_ctrl_test.sv
`timescale 1ns/1ps
module cg_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [3:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [3:0] rd_data;
    logic       pwr_en = 1'b1;
    logic       scan = 1'b0;
    logic [3:0] idle = 4'hF;
    logic [3:0] peri_g;
    logic [3:0] unit_g;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    cg_ctrl uut (
        .clk_cfg_i    (clk),
        .rst_ni       (rst_ni),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .pwr_clk_en_i (pwr_en),
        .scan_en_i    (scan),
        .idle_i       (idle),
        .peri_root_i  ({4{clk}}),
        .unit_root_i  ({4{clk}}),
        .peri_gclk_o  (peri_g),
        .unit_gclk_o  (unit_g)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All stimulus changes 1 ns after a rising edge
    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [3:0] d);
        step(1);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [3:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // Samples the next high phase of the gated clocks
    task automatic high_phase(output logic [3:0] p, output logic [3:0] u);
        @(posedge clk);
        #2;
        p = peri_g;
        u = unit_g;
    endtask

    task automatic t_reset();
        logic [3:0] d, p, u;
        read_reg(2'd0, d); chk("R1 enables reset", d, 4'hF);
        read_reg(2'd1, d); chk("R1 hints reset", d, 4'hF);
        high_phase(p, u);
        chk("R1 peri running", p, 4'hF);
        chk("R1 unit running", u, 4'hF);
    endtask

    task automatic t_readback();
        logic [3:0] d, p, u;
        write_reg(2'd0, 4'b1010);
        write_reg(2'd1, 4'b0110);
        read_reg(2'd0, d); chk("R2 enables readback", d, 4'b1010);
        read_reg(2'd1, d); chk("R2 hints readback", d, 4'b0110);
        step(3);
        high_phase(p, u);
        chk("R8 peri per-bit", p, 4'b1010);
        chk("R8 unit per-bit", u, 4'b0110);
        @(negedge clk); #2;
        chk("R9 peri low phase", peri_g, 4'h0);
        chk("R9 unit low phase", unit_g, 4'h0);
        write_reg(2'd0, 4'b0101);
        step(3);
        high_phase(p, u);
        chk("R8 peri second pattern", p, 4'b0101);
    endtask

    task automatic t_latency();
        logic [3:0] p, u;
        write_reg(2'd0, 4'hF);
        step(3);
        write_reg(2'd0, 4'b1110);
        // Returned 1 ns after the write edge k: current phase is edge k
        #1; chk("R3 write-edge phase keeps pulse", peri_g[0], 1'b1);
        high_phase(p, u); chk("R3 next phase keeps pulse", p[0], 1'b1);
        high_phase(p, u); chk("R3 second phase closed", p, 4'b1110);
        write_reg(2'd0, 4'hF);
        step(3);
    endtask

    task automatic t_busy();
        logic [3:0] p, u;
        write_reg(2'd1, 4'h0);
        step(3);
        high_phase(p, u); chk("R4 hints clear closes units", u, 4'h0);
        step(1);
        idle = 4'b1011;
        high_phase(p, u); chk("R4 busy unit runs", u, 4'b0100);
        step(1);
        idle = 4'hF;
        high_phase(p, u); chk("R4 idle again closes", u, 4'h0);
        write_reg(2'd1, 4'hF);
        step(3);
    endtask

    task automatic t_pwr();
        logic [3:0] p, u;
        step(1);
        pwr_en = 1'b0;
        idle = 4'b1110;
        step(3);
        high_phase(p, u);
        chk("R5 power off peri", p, 4'h0);
        chk("R5 power off keeps busy unit", u, 4'b0001);
        step(1);
        pwr_en = 1'b1;
        idle = 4'hF;
        step(3);
        high_phase(p, u); chk("R5 power back", p, 4'hF);
    endtask

    task automatic t_scan();
        logic [3:0] p, u;
        write_reg(2'd0, 4'h0);
        write_reg(2'd1, 4'h0);
        step(3);
        chk("R6 closed before scan", {peri_g, unit_g}, 8'h00);
        scan = 1'b1;
        #1;
        chk("R6 scan opens mid-phase", {peri_g, unit_g}, 8'hFF);
        high_phase(p, u); chk("R6 scan next phase", {p, u}, 8'hFF);
        step(1);
        scan = 1'b0;
        #1;
        chk("R6 scan released closes", {peri_g, unit_g}, 8'h00);
        write_reg(2'd0, 4'hF);
        write_reg(2'd1, 4'hF);
        step(3);
    endtask

    task automatic t_idle_status();
        logic [3:0] d;
        step(1);
        idle = 4'b0101;
        read_reg(2'd2, d); chk("R7 idle not yet synced", d, 4'hF);
        step(2);
        read_reg(2'd2, d); chk("R7 idle status synced", d, 4'b0101);
        write_reg(2'd2, 4'h0);
        read_reg(2'd0, d); chk("R7 write to status keeps enables", d, 4'hF);
        read_reg(2'd1, d); chk("R7 write to status keeps hints", d, 4'hF);
        read_reg(2'd2, d); chk("R7 status unchanged", d, 4'b0101);
        idle = 4'hF;
        step(3);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        step(4);
        rst_ni = 1'b1;
        step(2);
        t_reset();
        t_readback();
        t_latency();
        t_busy();
        t_pwr();
        t_scan();
        t_idle_status();
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end
endmodule